// File: doc/BRIEF.md
# Interrupt Flag Register with Framed Serial Access

This block holds the interrupt flags of a supervisory controller and gives a host access to them over a four-wire serial slave port. Internal status inputs, external pins and one-shot sources are brought into the system clock domain. Each source sets its own sticky flag on the edge or change that matters for it. While any flag is set and its enable bit is 1, an active-low interrupt line is asserted.

Every access is one 16-bit frame. The two leading bits select a register, and only the value 01 reaches the flags. The fourth bit chooses between a plain read and a read that also reloads the enable mask from the low twelve bits. A read returns the flags that were pending when chip select fell. When the frame completes, the read clears those flags and no others. A frame whose clock count is not exactly 16 is discarded and raises a frame-error flag. SCK, CS_N and MOSI are oversampled by the system clock, so SCK must be several times slower than the system clock.

Top module: `irq_spi_regs`

## Requirements
- R1: Bits are taken MSB first on rising SCK edges. Frame bits 15:14 select the register, and 01 is the interrupt register. A valid frame with any other value there clears no flag and leaves the enable mask unchanged.
- R2: In an interrupt-register frame, frame bit 12 set to 1 leaves the enable mask unchanged. Bit 12 set to 0 loads the mask from frame bits 11:0, and mask bits 4 and 0 are always stored as 0.
- R3: A frame that has not seen exactly 16 rising SCK edges when CS_N rises clears no flag and leaves the mask unchanged. It sets flag bit 8.
- R4: Flag bit 10 is set on any change of temp_warn_i, flag bit 9 on any change of gnd_shift_i, and flag bit 5 on any change of can_fail_i. A change in either direction counts.
- R5: Flag bit 7 is set on a falling edge of sense_pin_i, and flag bit 3 on a falling edge of wake_pin_i.
- R6: Flag bit 6 is set when any bit of supply_ok_i goes from 1 to 0. A return to 1 sets no flag.
- R7: Flag bit 11 is set on a rising edge of wdt_ovf_i, bit 2 on a rising edge of wdt_restart_i and bit 1 on a rising edge of can_wake_i. Bits 4 and 0 always read 0.
- R8: Flags are sticky. Only a valid 16-clock interrupt-register frame clears flags, and it clears only the flags that were returned in that frame.
- R9: An event that sets a flag after CS_N falls is not cleared by that frame and is returned by the next read.
- R10: During frame bits 15:12, MISO echoes the bits received on MOSI. Frame bits 11:0 carry the flags captured when CS_N fell.
- R11: irq_n_o is low exactly when some flag is set and its enable bit is 1.
- R12: After reset all flags and enables are 0, irq_n_o is high and miso_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock from the host |
| cs_n_i | input | 1 | Frame select, active low |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| temp_warn_i | input | 1 | Temperature warning status level |
| gnd_shift_i | input | 1 | Ground-shift diagnostic level |
| can_fail_i | input | 1 | Bus failure status level |
| sense_pin_i | input | 1 | Sense pin, falling edge is the event |
| wake_pin_i | input | 1 | Wake pin, falling edge is the event |
| supply_ok_i | input | SUPPLY_N | Supply good bits, a 1-to-0 transition is the event |
| wdt_ovf_i | input | 1 | Watchdog overflow in standby, rising edge |
| wdt_restart_i | input | 1 | Watchdog restart while disabled, rising edge |
| can_wake_i | input | 1 | Bus wake-up event, rising edge |
| irq_n_o | output | 1 | Interrupt request, active low |

## Verification
The assertions take for granted that every input holds a new level for at least two system clocks. They also assume that SCK high and low phases last long enough for each edge to be seen once after synchronization. Without these conditions an edge can be lost, and the checks on frame results and flag setting would then fail on a correct design. The stimulus keeps SCK phases at eight clocks and holds every pulse for six. It leaves at least eight quiet clocks after each event before a frame starts, so that the capture at CS_N fall sees the event.

// File: rtl/irq_spi_pkg.sv
package irq_spi_pkg;
  localparam int FRAME_W_DEF = 16;
  localparam int HDR_W_DEF   = 4;
  localparam int FLAG_W      = FRAME_W_DEF - HDR_W_DEF;

  // flag positions, decoded by host software
  localparam int B_WDT_OVF = 11;
  localparam int B_TEMP    = 10;
  localparam int B_GND     = 9;
  localparam int B_SPI     = 8;
  localparam int B_SENSE   = 7;
  localparam int B_SUPPLY  = 6;
  localparam int B_CANF    = 5;
  localparam int B_WAKE    = 3;
  localparam int B_WDT_RST = 2;
  localparam int B_CANW    = 1;

  localparam logic [FLAG_W-1:0] RSVD_MASK = 12'h011;

  typedef enum logic [1:0] {EDGE_ANY, EDGE_RISE, EDGE_FALL} edge_e;
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge
  import irq_spi_pkg::*;
#(
  parameter int    STAGES = 2,
  parameter edge_e MODE   = EDGE_ANY
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic evt_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic [STAGES:0]   arm_q;  // masks edges until the chain holds real input
  logic              cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      arm_q  <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], d_i};
      prev_q <= sync_q[STAGES-1];
      arm_q  <= {arm_q[STAGES-1:0], 1'b1};
    end
  end

  assign cur   = sync_q[STAGES-1];
  assign lvl_o = cur;

  generate
    if (MODE == EDGE_RISE) begin : g_rise
      assign evt_o = arm_q[STAGES] & cur & ~prev_q;
    end else if (MODE == EDGE_FALL) begin : g_fall
      assign evt_o = arm_q[STAGES] & ~cur & prev_q;
    end else begin : g_any
      assign evt_o = arm_q[STAGES] & (cur ^ prev_q);
    end
  endgenerate
endmodule

// File: rtl/irq_spi_frame.sv
module irq_spi_frame
  import irq_spi_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int HDR_W   = 4,
  parameter int STAGES  = 2,
  localparam int DAT_W  = FRAME_W - HDR_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sck_i,
  input  logic               cs_n_i,
  input  logic               mosi_i,
  input  logic [DAT_W-1:0]   snap_i,
  output logic               start_o,
  output logic               done_o,
  output logic               ok_o,
  output logic [FRAME_W-1:0] rx_o,
  output logic               miso_o
);
  localparam int CW = $clog2(FRAME_W + 2);
  localparam int IW = $clog2(DAT_W);
  localparam logic [CW-1:0] CNT_FULL = CW'(FRAME_W);
  localparam logic [CW-1:0] CNT_SAT  = CW'(FRAME_W + 1);
  localparam logic [CW-1:0] CNT_HDR  = CW'(HDR_W);

  logic sck_lvl, sck_evt, cs_lvl, cs_evt, mosi_s, unused_mosi_evt;
  logic sck_rise, cs_fall, cs_rise;
  logic active_q, miso_q, miso_d;
  logic [CW-1:0] cnt_q, idx;
  logic [FRAME_W-1:0] rx_q;

  irq_sync_edge #(.STAGES(STAGES), .MODE(EDGE_ANY)) u_sck (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sck_i), .lvl_o(sck_lvl), .evt_o(sck_evt));
  irq_sync_edge #(.STAGES(STAGES), .MODE(EDGE_ANY)) u_cs (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cs_n_i), .lvl_o(cs_lvl), .evt_o(cs_evt));
  irq_sync_edge #(.STAGES(STAGES), .MODE(EDGE_ANY)) u_mosi (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(mosi_i), .lvl_o(mosi_s), .evt_o(unused_mosi_evt));

  assign sck_rise = sck_evt & sck_lvl;
  assign cs_fall  = cs_evt & ~cs_lvl;
  assign cs_rise  = cs_evt & cs_lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      rx_q     <= '0;
      miso_q   <= 1'b0;
    end else begin
      miso_q <= miso_d;
      if (cs_fall) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        rx_q     <= '0;
      end else if (cs_rise) begin
        active_q <= 1'b0;
      end else if (active_q && sck_rise) begin
        rx_q <= {rx_q[FRAME_W-2:0], mosi_s};
        if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign idx = CNT_FULL - 1'b1 - cnt_q;

  always_comb begin
    if (!active_q)             miso_d = 1'b0;
    else if (cnt_q < CNT_HDR)  miso_d = mosi_s;
    else if (cnt_q < CNT_FULL) miso_d = snap_i[idx[IW-1:0]];
    else                       miso_d = 1'b0;
  end

  assign start_o = cs_fall;
  assign done_o  = cs_rise & active_q;
  assign ok_o    = (cnt_q == CNT_FULL);
  assign rx_o    = rx_q;
  assign miso_o  = miso_q;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_spi_pkg::*;
#(
  parameter int          FRAME_W  = 16,
  parameter int          HDR_W    = 4,
  parameter logic [1:0]  IRQ_ADDR = 2'b01,
  localparam int         DAT_W    = FRAME_W - HDR_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DAT_W-1:0]   evt_i,
  input  logic               start_i,
  input  logic               done_i,
  input  logic               ok_i,
  input  logic [FRAME_W-1:0] rx_i,
  output logic [DAT_W-1:0]   flags_o,
  output logic [DAT_W-1:0]   en_o,
  output logic [DAT_W-1:0]   snap_o
);
  logic [DAT_W-1:0] flags_q, en_q, snap_q, set_v, clr_v;
  logic addr_hit, ro_sel, rd_hit;

  assign addr_hit = (rx_i[FRAME_W-1 -: 2] == IRQ_ADDR);
  assign ro_sel   = rx_i[DAT_W];
  assign rd_hit   = done_i & ok_i & addr_hit;

  always_comb begin
    set_v = evt_i;
    if (done_i && !ok_i) set_v[B_SPI] = 1'b1;
    clr_v = rd_hit ? snap_q : '0;  // only what the host was shown
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      en_q    <= '0;
      snap_q  <= '0;
    end else begin
      flags_q <= ((flags_q & ~clr_v) | set_v) & ~RSVD_MASK;
      if (start_i) snap_q <= flags_q;
      if (rd_hit && !ro_sel) en_q <= rx_i[DAT_W-1:0] & ~RSVD_MASK;
    end
  end

  assign flags_o = flags_q;
  assign en_o    = en_q;
  assign snap_o  = snap_q;
endmodule

// File: rtl/irq_spi_regs.sv
module irq_spi_regs
  import irq_spi_pkg::*;
#(
  parameter int         FRAME_W     = FRAME_W_DEF,
  parameter int         HDR_W       = HDR_W_DEF,
  parameter int         SYNC_STAGES = 2,
  parameter int         SUPPLY_N    = 3,
  parameter logic [1:0] IRQ_ADDR    = 2'b01
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sck_i,
  input  logic                cs_n_i,
  input  logic                mosi_i,
  output logic                miso_o,
  input  logic                temp_warn_i,
  input  logic                gnd_shift_i,
  input  logic                can_fail_i,
  input  logic                sense_pin_i,
  input  logic                wake_pin_i,
  input  logic [SUPPLY_N-1:0] supply_ok_i,
  input  logic                wdt_ovf_i,
  input  logic                wdt_restart_i,
  input  logic                can_wake_i,
  output logic                irq_n_o
);
  localparam int DAT_W = FRAME_W - HDR_W;
  localparam int N_DET = 8;
  localparam edge_e DET_MODE [N_DET] = '{EDGE_ANY, EDGE_ANY, EDGE_ANY, EDGE_FALL,
                                         EDGE_FALL, EDGE_RISE, EDGE_RISE, EDGE_RISE};
  localparam int DET_POS [N_DET] = '{B_TEMP, B_GND, B_CANF, B_SENSE,
                                     B_WAKE, B_WDT_OVF, B_WDT_RST, B_CANW};

  logic [N_DET-1:0]    det_in, e_det, unused_det_lvl;
  logic [SUPPLY_N-1:0] e_sup, unused_sup_lvl;
  logic [DAT_W-1:0]    evt_vec, flags, en_mask, snap;
  logic [FRAME_W-1:0]  rx_word;
  logic frame_start, frame_done, frame_ok;

  assign det_in = {can_wake_i, wdt_restart_i, wdt_ovf_i, wake_pin_i,
                   sense_pin_i, can_fail_i, gnd_shift_i, temp_warn_i};

  for (genvar g = 0; g < N_DET; g++) begin : g_det
    irq_sync_edge #(.STAGES(SYNC_STAGES), .MODE(DET_MODE[g])) u_det (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(det_in[g]),
      .lvl_o(unused_det_lvl[g]), .evt_o(e_det[g]));
  end

  for (genvar g = 0; g < SUPPLY_N; g++) begin : g_sup
    irq_sync_edge #(.STAGES(SYNC_STAGES), .MODE(EDGE_FALL)) u_sup (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(supply_ok_i[g]),
      .lvl_o(unused_sup_lvl[g]), .evt_o(e_sup[g]));
  end

  always_comb begin
    evt_vec = '0;
    for (int k = 0; k < N_DET; k++) evt_vec[DET_POS[k]] = e_det[k];
    evt_vec[B_SUPPLY] = |e_sup;
  end

  irq_spi_frame #(.FRAME_W(FRAME_W), .HDR_W(HDR_W), .STAGES(SYNC_STAGES)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .sck_i(sck_i), .cs_n_i(cs_n_i), .mosi_i(mosi_i),
    .snap_i(snap), .start_o(frame_start), .done_o(frame_done), .ok_o(frame_ok),
    .rx_o(rx_word), .miso_o(miso_o));

  irq_flag_bank #(.FRAME_W(FRAME_W), .HDR_W(HDR_W), .IRQ_ADDR(IRQ_ADDR)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_vec), .start_i(frame_start),
    .done_i(frame_done), .ok_i(frame_ok), .rx_i(rx_word),
    .flags_o(flags), .en_o(en_mask), .snap_o(snap));

  assign irq_n_o = ~|(flags & en_mask);
endmodule

// File: rtl/irq_spi_regs_chk.sv
module irq_spi_regs_chk
  import irq_spi_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [FLAG_W-1:0] flags,
  input logic [FLAG_W-1:0] en_mask,
  input logic [FLAG_W-1:0] evt_vec,
  input logic              frame_done,
  input logic              frame_ok,
  input logic [15:0]       rx_word
);
  p_bad_frame_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done && !frame_ok |=> flags[B_SPI]);

  p_bad_frame_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done && !frame_ok |=> $stable(en_mask));

  p_ro_keeps_en_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done && frame_ok && rx_word[12] |=> $stable(en_mask));

  p_other_addr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done && rx_word[15:14] != 2'b01 |=> $stable(en_mask));

  p_evt_kept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_vec) |=> ((flags & $past(evt_vec)) == $past(evt_vec)));

  p_clear_on_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(flags) & ~flags)) |-> $past(frame_done && frame_ok && rx_word[15:14] == 2'b01));
endmodule

bind irq_spi_regs irq_spi_regs_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .flags(flags), .en_mask(en_mask), .evt_vec(evt_vec),
  .frame_done(frame_done), .frame_ok(frame_ok), .rx_word(rx_word));

// File: tb/sim_irq_spi_regs.sv
`timescale 1ns/1ps
module sim_irq_spi_regs;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic temp = 1'b0, gnd = 1'b0, canf = 1'b0, sense = 1'b1, wake = 1'b1;
  logic [2:0] supply = 3'b111;
  logic wovf = 1'b0, wrst = 1'b0, canw = 1'b0;
  logic miso, irq_n;

  logic [11:0] mf = '0, men = '0;
  int cyc = 0, last_stim = 0;
  int n_chk = 0, n_err = 0, mon_chk = 0, mon_err = 0;

  always #2 clk = ~clk;

  irq_spi_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_n_i(cs_n), .mosi_i(mosi), .miso_o(miso),
    .temp_warn_i(temp), .gnd_shift_i(gnd), .can_fail_i(canf), .sense_pin_i(sense),
    .wake_pin_i(wake), .supply_ok_i(supply), .wdt_ovf_i(wovf), .wdt_restart_i(wrst),
    .can_wake_i(canw), .irq_n_o(irq_n));

  // interrupt line compared on every quiet clock (R11)
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n && (cyc - last_stim > 12)) begin
      mon_chk = mon_chk + 1;
      if (irq_n !== ~|(mf & men)) begin
        mon_err = mon_err + 1;
        $display("FAIL R11 irq_n act=%b exp=%b at cycle %0d", irq_n, ~|(mf & men), cyc);
      end
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic fire(input int k);
    @(negedge clk);
    last_stim = cyc;
    case (k)
      0: begin temp = ~temp; mf[10] = 1'b1; end
      1: begin gnd  = ~gnd;  mf[9]  = 1'b1; end
      2: begin canf = ~canf; mf[5]  = 1'b1; end
      3: begin sense = 1'b0; mf[7]  = 1'b1; end
      4: begin wake  = 1'b0; mf[3]  = 1'b1; end
      5: begin supply[1] = 1'b0; mf[6] = 1'b1; end
      6: begin wovf = 1'b1; mf[11] = 1'b1; end
      7: begin wrst = 1'b1; mf[2]  = 1'b1; end
      default: begin canw = 1'b1; mf[1] = 1'b1; end
    endcase
    repeat (6) @(negedge clk);
    sense = 1'b1; wake = 1'b1; supply = 3'b111; wovf = 1'b0; wrst = 1'b0; canw = 1'b0;
    last_stim = cyc;
    repeat (8) @(negedge clk);
  endtask

  task automatic frame(input int nclk, input logic [15:0] w, input int mid,
                       output logic [15:0] r);
    logic [11:0] snap;
    r = '0;
    @(negedge clk);
    cs_n = 1'b0;
    snap = mf;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nclk; i++) begin
      mosi = (i < 16) ? w[15-i] : 1'b0;
      if (i == 8 && mid >= 0) fire(mid);
      repeat (HALF) @(negedge clk);
      if (i < 16) r[15-i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    last_stim = cyc;
    if (nclk != 16) mf[8] = 1'b1;
    else if (w[15:14] == 2'b01) begin
      mf = mf & ~snap;
      if (!w[12]) men = w[11:0] & 12'hFEE;
    end
    if (nclk == 16) chk("R10 miso frame", r, {w[15:12], snap});
    repeat (3 * HALF) @(negedge clk);
  endtask

  task automatic rd(input string req, input logic [11:0] exp);
    logic [15:0] r;
    frame(16, 16'h5000, -1, r);
    chk(req, r, {4'h5, exp});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk + mon_chk + 1, n_err + mon_err + 1);
    $finish;
  end

  initial begin
    logic [15:0] r;
    repeat (5) @(negedge clk);
    chk("R12 irq at reset", {15'd0, irq_n}, 16'd1);
    chk("R12 miso at reset", {15'd0, miso}, 16'd0);
    rst_n = 1'b1;
    last_stim = cyc;
    repeat (12) @(negedge clk);
    rd("R12 flags clear", 12'h000);

    frame(16, 16'h4FFF, -1, r);             // R2 load mask
    rd("R2 read after mask load", 12'h000);
    chk("R11 idle irq", {15'd0, irq_n}, 16'd1);

    fire(0);
    chk("R11 irq asserted", {15'd0, irq_n}, 16'd0);
    rd("R4 temp change", 12'h400);
    fire(1); fire(2);
    rd("R4 gnd and can fail change", 12'h220);
    fire(0);
    rd("R4 temp change back", 12'h400);

    fire(3); fire(4);
    rd("R5 sense and wake falls", 12'h088);
    fire(5);
    rd("R6 supply drop", 12'h040);
    rd("R6 supply restore no flag", 12'h000);
    fire(6); fire(7); fire(8);
    rd("R7 one-shot sources", 12'h806);

    frame(15, 16'h4000, -1, r);
    rd("R3 short frame flag", 12'h100);
    fire(1);
    chk("R3 mask kept after short frame", {15'd0, irq_n}, 16'd0);
    rd("R3 gnd after short frame", 12'h200);
    fire(0);
    frame(17, 16'h5000, -1, r);
    rd("R8 long frame clears nothing", 12'h500);
    frame(0, 16'h0000, -1, r);
    rd("R3 empty frame", 12'h100);

    frame(16, 16'h4400, -1, r);
    fire(1);
    repeat (20) @(negedge clk);
    chk("R11 masked flag", {15'd0, irq_n}, 16'd1);
    fire(0);
    chk("R11 enabled flag", {15'd0, irq_n}, 16'd0);
    rd("R11 both flags pending", 12'h600);

    fire(4);
    frame(16, 16'h8000, -1, r);
    rd("R1 other address keeps flags", 12'h008);
    fire(0);
    chk("R1 other address keeps mask", {15'd0, irq_n}, 16'd0);
    rd("R1 read", 12'h400);

    fire(2);
    repeat (300) @(negedge clk);
    rd("R8 sticky flag", 12'h020);

    frame(16, 16'h5000, 8, r);
    chk("R9 mid-frame event not in snapshot", {4'h0, r[11:0]}, 16'h0000);
    rd("R9 mid-frame event kept", 12'h002);

    frame(16, 16'h50FF, -1, r);
    fire(1);
    chk("R2 read-only keeps mask", {15'd0, irq_n}, 16'd1);
    fire(0);
    chk("R2 read-only keeps mask bit 10", {15'd0, irq_n}, 16'd0);
    rd("R2 read", 12'h600);

    fire(3);
    frame(16, 16'hF5A5, -1, r);
    chk("R10 header echo", r, 16'hF080);
    frame(16, 16'h6000, -1, r);
    chk("R10 header echo addr 01", r, 16'h6080);
    fire(0);
    chk("R2 mask cleared by write", {15'd0, irq_n}, 16'd1);
    rd("R2 read after clear", 12'h400);

    repeat (20) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk + mon_chk, n_err + mon_err);
    $finish;
  end
endmodule